// File: doc/BRIEF.md
# Thermal Conversion Scheduler with Sample Averaging

This block paces temperature conversions for up to three sensor channels. A free-running period timer opens a new measurement round every 4096 × (P+1) clocks. In each round the scheduler visits every enabled channel in ascending index order. For each channel it first holds an acquire window of N+1 clocks and then requests one 12-bit conversion from an external converter over a request/acknowledge handshake.

Every returned code goes to that channel's averager. With averaging off, the code goes straight to the channel's result register. With averaging on, the averager sums a power-of-two number of codes and then writes the truncated mean. Each result update comes with a one-cycle ready strobe for that channel.

Configuration arrives as plain input ports. Disabling a channel clears its partial sum. Changing the period value restarts the timer and drops every partial sum.

Top module: `thermal_sampler`

## Requirements
- R1: While rst_n is low, adc_req is 0, data_ready is all zero and data_out is all zero.
- R2: Within one round, adc_req stays low for exactly cfg_acq+1 clock cycles between the cycle in which a conversion is acknowledged and the next request.
- R3: With no configuration change, the first requests of successive rounds rise exactly 4096·(cfg_period+1) clocks apart. The 4096 unit is 2^UNIT_LOG.
- R4: Within a round, requests cover only channels whose cfg_en bit is set (bit i enables channel i). They run in strictly ascending adc_ch order (adc_ch carries the channel index), starting from the lowest enabled channel. A disabled channel never produces a ready strobe.
- R5: When cfg_filter bit 2 is 0, each accepted code (a cycle with adc_req and adc_ack both high) is written unchanged to its channel's result in the following cycle. Outside of a ready strobe the result does not change.
- R6: When cfg_filter bit 2 is 1, a channel averages 2^(cfg_filter[1:0]+1) accepted codes, so code 5 averages 4 and code 6 averages 8. The result is the sum shifted right by the log2 of that count, truncating.
- R7: data_ready[i] pulses for one cycle, in the cycle after the accepted code that completes channel i's count. The result sits at data_out[12i+11:12i].
- R8: Clearing a channel's enable bit discards its partial sum. After re-enabling, the next result averages only codes accepted after the re-enable.
- R9: A change of cfg_period restarts the round timer, withdraws any pending request in the next cycle and discards every channel's partial sum.
- R10: Once raised, adc_req stays high with a stable adc_ch until adc_ack is seen, unless the channel is disabled or the period changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_acq | input | ACQ_W | Acquire window length minus one, in clocks |
| cfg_period | input | PER_W | Round period multiplier minus one |
| cfg_filter | input | 3 | Bit 2 enables averaging; bits 1:0 select 2^(v+1) samples |
| cfg_en | input | NUM_CH | Per-channel enable, bit i for channel i |
| adc_ack | input | 1 | Converter acknowledge; code valid in this cycle |
| adc_code | input | DATA_W | Converted code |
| adc_req | output | 1 | Conversion request |
| adc_ch | output | CH_W | Channel index of the request |
| data_out | output | NUM_CH*DATA_W | Per-channel results, channel i at bits DATA_W*i upward |
| data_ready | output | NUM_CH | One-cycle result strobe per channel |

## Verification
On every cycle, the embedded properties check several things. The request must be held until acknowledged and is withdrawn after a period change. A request may start only for an enabled channel. Each ready strobe lasts one cycle, follows an accepted code on an enabled channel, and a result changes only under its strobe. A period change is followed at once by a fresh round.

Several behaviours only show up in the bench's sweeps over filter codes, enable patterns, acquire lengths and periods:
- the exact acquire gap and round spacing;
- the ascending visiting order;
- the arithmetic of the truncated mean;
- the fresh average after a disable or a period change.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_e;

  localparam int FILT_W  = 3;
  localparam int MAX_LOG = 4;

  // log2 of the number of codes averaged for a filter setting
  function automatic logic [2:0] avg_log(input logic [FILT_W-1:0] code);
    if (code[2]) avg_log = {1'b0, code[1:0]} + 3'd1;
    else         avg_log = 3'd0;
  endfunction

endpackage

// File: rtl/thermal_period_timer.sv
module thermal_period_timer #(
  parameter int PER_W    = 16,
  parameter int UNIT_LOG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] cfg_period,
  output logic             start,
  output logic             flush
);
  localparam int CNT_W = PER_W + UNIT_LOG;

  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] terminal;

  assign flush    = (cfg_period != per_q);
  assign terminal = {per_q, {UNIT_LOG{1'b1}}};
  assign start    = (cnt_q == '0) && !flush;

  always_comb begin
    if (flush)                 cnt_d = '0;
    else if (cnt_q == terminal) cnt_d = '0;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush) per_q <= cfg_period;
    end
  end

  // a restart is followed by a new round in the very next cycle
  assert_restart_round_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && !flush) |-> start);

  // the last count of a period is followed by a round start
  assert_period_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == terminal && !flush && cfg_period == per_q) |=> (start || flush));

endmodule

// File: rtl/thermal_conv_seq.sv
module thermal_conv_seq
  import thermal_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ACQ_W  = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              flush,
  input  logic [ACQ_W-1:0]  cfg_acq,
  input  logic [NUM_CH-1:0] cfg_en,
  input  logic              adc_ack,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_ch,
  output logic              smp_valid
);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [ACQ_W-1:0]  acq_q, acq_d;

  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] pick_mask;
  logic [CH_W-1:0]   pick_ch;
  logic              pick_any;
  logic              cur_en;
  logic              adv;

  // candidate set: full enable mask at round start, remaining ones later
  always_comb begin
    cand     = (state_q == SEQ_IDLE) ? cfg_en : (pend_q & cfg_en);
    pick_any = |cand;
    pick_ch  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) pick_ch = CH_W'(i);
    end
    pick_mask = cand & ~(NUM_CH'(1) << pick_ch);
  end

  always_comb begin
    cur_en = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_q == CH_W'(i)) cur_en = cfg_en[i];
    end
  end

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    pend_d  = pend_q;
    acq_d   = acq_q;
    adv     = 1'b0;
    case (state_q)
      SEQ_IDLE: if (start) adv = 1'b1;
      SEQ_ACQ: begin
        if (!cur_en)             adv = 1'b1;
        else if (acq_q == '0)    state_d = SEQ_CONV;
        else                     acq_d = acq_q - ACQ_W'(1);
      end
      SEQ_CONV: if (!cur_en || adc_ack) adv = 1'b1;
      default: state_d = SEQ_IDLE;
    endcase
    if (adv) begin
      if (pick_any) begin
        state_d = SEQ_ACQ;
        ch_d    = pick_ch;
        pend_d  = pick_mask;
        acq_d   = cfg_acq;
      end else begin
        state_d = SEQ_IDLE;
        pend_d  = '0;
      end
    end
    if (flush) begin
      state_d = SEQ_IDLE;
      pend_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
      pend_q  <= '0;
      acq_q   <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      pend_q  <= pend_d;
      acq_q   <= acq_d;
    end
  end

  assign adc_req   = (state_q == SEQ_CONV);
  assign adc_ch    = ch_q;
  assign smp_valid = adc_req && adc_ack && cur_en && !flush;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack && !flush && cur_en) |=> (adc_req && $stable(adc_ch)));

  assert_req_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !adc_req);

  assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_req) |-> $past(cur_en));

endmodule

// File: rtl/thermal_ch_avg.sv
module thermal_ch_avg
  import thermal_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              flush,
  input  logic [FILT_W-1:0] filt,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_code,
  output logic [DATA_W-1:0] data,
  output logic              ready
);
  localparam int ACC_W = DATA_W + MAX_LOG;
  localparam int CNT_W = MAX_LOG + 1;

  logic [ACC_W-1:0]  acc_q, acc_d, sum, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, target;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ready_q, ready_d;
  logic [2:0]        lg;
  logic              done;

  assign lg      = avg_log(filt);
  assign target  = CNT_W'(1) << lg;
  assign sum     = acc_q + ACC_W'(smp_code);
  assign shifted = sum >> lg;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign done    = smp_valid && (cnt_inc >= target);

  always_comb begin
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    ready_d = 1'b0;
    if (!en || flush) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (smp_valid) begin
      if (done) begin
        acc_d   = '0;
        cnt_d   = '0;
        data_d  = shifted[DATA_W-1:0];
        ready_d = 1'b1;
      end else begin
        acc_d = sum;
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      if (ready_d) data_q <= data_d;
    end
  end

  assign data  = data_q;
  assign ready = ready_q;

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_ready_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(smp_valid));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(data));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(en));

endmodule

// File: rtl/thermal_sampler.sv
module thermal_sampler
  import thermal_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int DATA_W   = 12,
  parameter int ACQ_W    = 16,
  parameter int PER_W    = 16,
  parameter int UNIT_LOG = 12,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ACQ_W-1:0]         cfg_acq,
  input  logic [PER_W-1:0]         cfg_period,
  input  logic [FILT_W-1:0]        cfg_filter,
  input  logic [NUM_CH-1:0]        cfg_en,
  input  logic                     adc_ack,
  input  logic [DATA_W-1:0]        adc_code,
  output logic                     adc_req,
  output logic [CH_W-1:0]          adc_ch,
  output logic [NUM_CH*DATA_W-1:0] data_out,
  output logic [NUM_CH-1:0]        data_ready
);

  logic start, flush, smp_valid;

  thermal_period_timer #(
    .PER_W    (PER_W),
    .UNIT_LOG (UNIT_LOG)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .start      (start),
    .flush      (flush)
  );

  thermal_conv_seq #(
    .NUM_CH (NUM_CH),
    .ACQ_W  (ACQ_W),
    .CH_W   (CH_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .flush     (flush),
    .cfg_acq   (cfg_acq),
    .cfg_en    (cfg_en),
    .adc_ack   (adc_ack),
    .adc_req   (adc_req),
    .adc_ch    (adc_ch),
    .smp_valid (smp_valid)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_hit;
    assign ch_hit = smp_valid && (adc_ch == CH_W'(g));

    thermal_ch_avg #(
      .DATA_W (DATA_W)
    ) u_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en[g]),
      .flush     (flush),
      .filt      (cfg_filter),
      .smp_valid (ch_hit),
      .smp_code  (adc_code),
      .data      (data_out[g*DATA_W +: DATA_W]),
      .ready     (data_ready[g])
    );
  end

  assert_one_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_ready));

endmodule

// File: tb/thermal_sampler_test.sv
`timescale 1ns/1ps
module thermal_sampler_test;
  localparam int NCH  = 3;
  localparam int DW   = 12;
  localparam int AW   = 8;
  localparam int PW   = 4;
  localparam int ULOG = 6;
  localparam int UNIT = 1 << ULOG;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   cfg_acq;
  logic [PW-1:0]   cfg_period;
  logic [2:0]      cfg_filter;
  logic [NCH-1:0]  cfg_en;
  logic            adc_ack;
  logic [DW-1:0]   adc_code;
  logic            adc_req;
  logic [1:0]      adc_ch;
  logic [NCH*DW-1:0] data_out;
  logic [NCH-1:0]  data_ready;

  thermal_sampler #(
    .NUM_CH(NCH), .DATA_W(DW), .ACQ_W(AW), .PER_W(PW), .UNIT_LOG(ULOG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_acq(cfg_acq), .cfg_period(cfg_period),
    .cfg_filter(cfg_filter), .cfg_en(cfg_en), .adc_ack(adc_ack),
    .adc_code(adc_code), .adc_req(adc_req), .adc_ch(adc_ch),
    .data_out(data_out), .data_ready(data_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  int  m_sum [NCH];
  int  m_cnt [NCH];
  bit  exp_due [NCH];
  int  exp_val [NCH];
  int  rdy_seen [NCH];

  bit  ack_drv = 0;
  bit  in_req = 0;
  int  hold = 0;
  int  held = 0;
  int  ack_delay = 0;
  int  gap = 0;
  bit  gap_ok = 0;
  int  prev_ch = -1;
  int  first_t = 0;
  bit  first_ok = 0;
  logic [31:0] seed = 32'h1234_5677;
  string dtag = "R5";

  task automatic check(input bit cond, input string rq, input string what,
                       input int act, input int expv);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  function automatic int lg_of(input logic [2:0] f);
    return f[2] ? (int'(f[1:0]) + 1) : 0;
  endfunction

  function automatic int lowest(input logic [NCH-1:0] en);
    for (int i = NCH - 1; i >= 0; i--) if (en[i]) lowest = i;
    if (en == '0) lowest = -1;
  endfunction

  task automatic clear_model(input int c);
    m_sum[c] = 0;
    m_cnt[c] = 0;
  endtask

  task automatic reset_track();
    prev_ch = -1;
    first_ok = 0;
    gap_ok = 0;
  endtask

  task automatic step();
    int c, code, lg;
    @(negedge clk);
    cyc++;
    for (int k = 0; k < NCH; k++) begin
      if (data_ready[k] || exp_due[k]) begin
        check(data_ready[k] == exp_due[k], "R7", "ready strobe",
              int'(data_ready[k]), int'(exp_due[k]));
        if (data_ready[k] && exp_due[k]) begin
          check(int'(data_out[k*DW +: DW]) == exp_val[k], dtag, "result value",
                int'(data_out[k*DW +: DW]), exp_val[k]);
          rdy_seen[k]++;
        end
        exp_due[k] = 0;
      end
    end
    if (ack_drv) begin
      ack_drv = 0;
      adc_ack = 1'b0;
      gap = 0;
    end
    if (!adc_req) begin
      if (in_req) begin
        check(1'b0, "R10", "request withdrawn before ack", 0, 1);
        in_req = 0;
      end
      gap++;
    end else begin
      c = int'(adc_ch);
      if (!in_req) begin
        check(cfg_en[c] == 1'b1, "R4", "request for disabled channel", c, lowest(cfg_en));
        if (prev_ch >= 0 && c <= prev_ch) begin
          check(c == lowest(cfg_en), "R4", "round starts at lowest channel", c, lowest(cfg_en));
          if (first_ok)
            check(cyc - first_t == UNIT * (int'(cfg_period) + 1), "R3", "round spacing",
                  cyc - first_t, UNIT * (int'(cfg_period) + 1));
          first_t = cyc;
          first_ok = 1;
        end else if (prev_ch >= 0 && gap_ok) begin
          check(gap == int'(cfg_acq) + 1, "R2", "acquire gap", gap, int'(cfg_acq) + 1);
        end
        prev_ch = c;
        gap_ok = 1;
        in_req = 1;
        hold = 0;
        held = c;
      end else begin
        check(c == held, "R10", "channel changed while waiting", c, held);
      end
      if (hold < ack_delay) begin
        hold++;
      end else begin
        seed = seed * 32'd1103515245 + 32'd12345;
        code = int'(seed[27:16]);
        adc_code = seed[27:16];
        adc_ack = 1'b1;
        ack_drv = 1;
        in_req = 0;
        if (cfg_en[held]) begin
          lg = lg_of(cfg_filter);
          m_sum[held] += code;
          m_cnt[held]++;
          if (m_cnt[held] >= (1 << lg)) begin
            exp_due[held] = 1;
            exp_val[held] = m_sum[held] >> lg;
            clear_model(held);
          end
        end
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic settle();
    while (ack_drv || in_req) step();
  endtask

  task automatic verify_seen(input string rq);
    for (int k = 0; k < NCH; k++) begin
      if (cfg_en[k]) check(rdy_seen[k] > 0, rq, "enabled channel produced results", rdy_seen[k], 1);
      else check(rdy_seen[k] == 0, "R4", "disabled channel produced results", rdy_seen[k], 0);
    end
  endtask

  task automatic apply_cfg(input logic [2:0] en, input logic [2:0] f,
                           input int p, input int n);
    settle();
    cfg_en = '0;
    for (int k = 0; k < NCH; k++) clear_model(k);
    step();
    cfg_filter = f;
    cfg_acq    = AW'(n);
    cfg_period = PW'(p);
    cfg_en     = en;
    for (int k = 0; k < NCH; k++) begin
      clear_model(k);
      rdy_seen[k] = 0;
    end
    reset_track();
    dtag = f[2] ? "R6" : "R5";
  endtask

  task automatic set_en(input logic [2:0] en);
    settle();
    for (int k = 0; k < NCH; k++) if (cfg_en[k] && !en[k]) clear_model(k);
    cfg_en = en;
    reset_track();
  endtask

  task automatic set_period(input int p);
    settle();
    for (int k = 0; k < NCH; k++) clear_model(k);
    cfg_period = PW'(p);
    reset_track();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int nt[5];
    logic [2:0] fl[6];
    logic [2:0] el[3];
    int idx, cycles;
    nt = '{0, 1, 3, 7, 12};
    fl = '{3'd0, 3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
    el = '{3'd7, 3'd5, 3'd2};
    for (int k = 0; k < NCH; k++) begin
      clear_model(k);
      exp_due[k] = 0;
      exp_val[k] = 0;
      rdy_seen[k] = 0;
    end
    rst_n = 1'b0;
    cfg_acq = '0;
    cfg_period = '0;
    cfg_filter = '0;
    cfg_en = '0;
    adc_ack = 1'b0;
    adc_code = '0;
    repeat (3) @(negedge clk);
    check(adc_req == 1'b0, "R1", "request in reset", int'(adc_req), 0);
    check(data_ready == '0, "R1", "ready in reset", int'(data_ready), 0);
    check(data_out == '0, "R1", "results in reset", int'(data_out[31:0]), 0);
    rst_n = 1'b1;
    run(4);

    // sweep periods, filter codes, enable patterns and acquire lengths
    for (int pi = 0; pi < 2; pi++) begin
      for (int fi = 0; fi < 6; fi++) begin
        for (int ei = 0; ei < 3; ei++) begin
          idx = (pi * 7 + fi * 3 + ei) % 5;
          apply_cfg(el[ei], fl[fi], pi, nt[idx]);
          cycles = UNIT * (pi + 1) * ((1 << lg_of(fl[fi])) + 2) + 100;
          run(cycles);
          verify_seen(dtag);
        end
      end
    end

    // R10: converter answers late; request must wait
    apply_cfg(3'd7, 3'd5, 0, 2);
    ack_delay = 3;
    dtag = "R10";
    run(UNIT * 8);
    verify_seen("R10");
    settle();
    ack_delay = 0;

    // R8: disable channel 1 mid-average, then re-enable
    apply_cfg(3'd7, 3'd6, 0, 2);
    dtag = "R8";
    run(UNIT * 3 + 10);
    set_en(3'd5);
    run(UNIT * 2);
    set_en(3'd7);
    for (int k = 0; k < NCH; k++) rdy_seen[k] = 0;
    run(UNIT * 12);
    verify_seen("R8");

    // R9: period change with partial sums outstanding
    apply_cfg(3'd7, 3'd6, 0, 1);
    dtag = "R9";
    run(UNIT * 3 + 20);
    set_period(1);
    for (int k = 0; k < NCH; k++) rdy_seen[k] = 0;
    run(UNIT * 2 * 12);
    verify_seen("R9");

    settle();
    run(4);
    finish_run();
  end

endmodule